// File: doc/BRIEF.md
# Three-colour CCD pixel sampling and serial output controller

This block sequences the digital side of a three-colour CCD front end, one pixel at a time. A host pulse on `start_i` opens a pixel cycle. Once that pulse ends, the block counts clock cycles and raises a one-cycle black-level sample strobe and then a one-cycle video-level sample strobe, each at its own programmed 8-bit count. The analog stage takes the difference of the two samples. After the video sample, the held pixel goes to a single shared successive-approximation converter. The converter resolves the red, green and blue channels in that order, one bit per clock, reading a comparator input and driving the trial code and the channel multiplexer select.

When the blue result is complete, the three 10-bit words go out at the same time on three serial pins, one per colour, MSB first, with a shift strobe and a first-bit marker. Sampling of the next pixel may run while the converter and the serializer are still working on the previous one. A start that arrives while the sampler still holds an earlier pixel is flagged and dropped. A start whose video position does not come after its black position is also flagged and dropped.

The block also holds per-channel 8-bit offset and gain settings and drives them out to the analog amplifiers.

Top module: `ccd_pix_seq`

## Requirements
- R1: After reset, every strobe, flag, the busy and shift outputs, the trial code, the serial pins and all gain and offset outputs are 0.
- R2: A rising `start_i` is accepted only when the sampler is idle. Counting begins at the first clock edge that samples `start_i` low. With that edge called edge 0, `blk_smp_o` is high for exactly the one cycle that begins at edge B, and `vid_smp_o` is high for exactly the one cycle that begins at edge V. B and V are the `blk_pos_i` and `vid_pos_i` values captured at acceptance. The black strobe always comes before the video strobe.
- R3: If a rising `start_i` finds the sampler idle but `vid_pos_i` <= `blk_pos_i`, then `order_err_o` pulses for one cycle in the cycle after that edge, and the pixel is dropped: no strobe follows.
- R4: If a rising `start_i` finds the sampler busy (waiting for START to end, counting, or holding samples not yet passed to the converter), then `overrun_o` pulses for one cycle in the next cycle and the start is dropped. The strobe timing of the pixel in progress is unchanged.
- R5: A held pixel is passed to the converter on the first clock edge at which the converter is idle. The converter resolves channels in the order `mux_sel_o` = 0 (red), 1 (green), 2 (blue). Each channel takes 10 cycles, MSB first. `sar_trial_o` is the bits kept so far with the current bit set, and the bit is kept when `comp_i` is 1. The bench comparator drives `comp_i` = (channel value >= `sar_trial_o`), so the resolved word equals the channel value.
- R6: After the blue channel's last bit, `shift_o` is high for 10 consecutive cycles. Pins `ser_o[0]`, `ser_o[1]` and `ser_o[2]` carry the red, green and blue words MSB first, one bit per cycle. `word_o` is high only in the first of those cycles.
- R7: A new pixel can be accepted and sampled while the converter is still busy with the previous pixel. Results leave in the order the pixels were accepted.
- R8: A cycle with `cfg_we_i` high writes `cfg_data_i` into channel `cfg_ch_i` (0 to 2): into the gain when `cfg_gain_sel_i` is 1, into the offset when it is 0. Channel c drives bits [8c+7:8c] of `gain_o` and `offs_o`. A write to channel 3 changes nothing, and the outputs change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host pixel-cycle start pulse |
| blk_pos_i | input | 8 | Black-level sample position, cycles after START ends |
| vid_pos_i | input | 8 | Video-level sample position, cycles after START ends |
| comp_i | input | 1 | Comparator result for the current trial code |
| cfg_we_i | input | 1 | Setting write enable |
| cfg_ch_i | input | 2 | Channel addressed by a setting write |
| cfg_gain_sel_i | input | 1 | 1 = write gain, 0 = write offset |
| cfg_data_i | input | 8 | Setting write data |
| blk_smp_o | output | 1 | Black-level sample strobe |
| vid_smp_o | output | 1 | Video-level sample strobe |
| order_err_o | output | 1 | Pulse: start dropped because the video position is not after the black position |
| overrun_o | output | 1 | Pulse: start dropped because the sampler is busy |
| conv_busy_o | output | 1 | Converter working |
| mux_sel_o | output | 2 | Channel under conversion (0 R, 1 G, 2 B) |
| sar_trial_o | output | 10 | Trial code for the comparator DAC |
| ser_o | output | 3 | Serial data, one pin per colour |
| shift_o | output | 1 | Serial shift strobe |
| word_o | output | 1 | Marks the first bit of each 10-bit word |
| offs_o | output | 24 | Per-channel offset settings |
| gain_o | output | 24 | Per-channel gain settings |

## Verification
The properties assume that `comp_i` settles within the cycle from the registered trial code and select, and that `cfg_we_i` stays low during reset. The bench derives `comp_i` combinationally from a per-pixel table of channel values, so each conversion's expected word is known in advance. In the random phase the bench leaves a gap of at least 35 cycles after each video strobe before the next start, so random starts are never dropped. Overruns, order errors and overlapping pixels are produced only by the directed cases, where the bench knows that outcome in advance.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned CCD_NCH  = 3;
  localparam int unsigned CCD_POSW = 8;
  localparam int unsigned CCD_ADCW = 10;
  localparam int unsigned CCD_CFGW = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARM   = 2'd1,
    SQ_COUNT = 2'd2,
    SQ_HELD  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/ccd_samp_seq.sv
module ccd_samp_seq
  import ccd_pkg::*;
#(
  parameter int unsigned POSW = CCD_POSW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [POSW-1:0] blk_pos_i,
  input  logic [POSW-1:0] vid_pos_i,
  input  logic            conv_idle_i,
  output logic            blk_smp_o,
  output logic            vid_smp_o,
  output logic            order_err_o,
  output logic            overrun_o,
  output logic            handoff_o
);
  sq_state_e       state_q, state_d;
  logic [POSW-1:0] cnt_q, cnt_d;
  logic [POSW-1:0] blk_q, vid_q;
  logic            start_q;
  logic            err_q, ovr_q;
  logic            rise, accept, bad_order, drop_busy, blk_hit, vid_hit, cnt_en;

  always_comb begin
    rise      = start_i & ~start_q;
    accept    = rise && (state_q == SQ_IDLE) && (vid_pos_i > blk_pos_i);
    bad_order = rise && (state_q == SQ_IDLE) && !(vid_pos_i > blk_pos_i);
    drop_busy = rise && (state_q != SQ_IDLE);
    blk_hit   = (state_q == SQ_COUNT) && (cnt_q == blk_q);
    vid_hit   = (state_q == SQ_COUNT) && (cnt_q == vid_q);
    handoff_o = (state_q == SQ_HELD) && conv_idle_i;
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    unique case (state_q)
      SQ_IDLE:  if (accept) state_d = SQ_ARM;
      SQ_ARM:   if (!start_i) begin
                  state_d = SQ_COUNT;
                  cnt_d   = '0;
                  cnt_en  = 1'b1;
                end
      SQ_COUNT: if (vid_hit) state_d = SQ_HELD;
                else begin
                  cnt_d  = cnt_q + 1'b1;
                  cnt_en = 1'b1;
                end
      SQ_HELD:  if (handoff_o) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      blk_q   <= '0;
      vid_q   <= '0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
      err_q   <= bad_order;
      ovr_q   <= drop_busy;
      if (cnt_en) cnt_q <= cnt_d;
      if (accept) begin
        blk_q <= blk_pos_i;
        vid_q <= vid_pos_i;
      end
    end
  end

  assign blk_smp_o   = blk_hit;
  assign vid_smp_o   = vid_hit;
  assign order_err_o = err_q;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/ccd_sar_conv.sv
module ccd_sar_conv
  import ccd_pkg::*;
#(
  parameter int unsigned ADCW = CCD_ADCW,
  parameter int unsigned NCH  = CCD_NCH,
  localparam int unsigned CHW  = $clog2(NCH),
  localparam int unsigned BITW = $clog2(ADCW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic                comp_i,
  output logic                busy_o,
  output logic [CHW-1:0]      sel_o,
  output logic [ADCW-1:0]     trial_o,
  output logic                done_o,
  output logic [NCH*ADCW-1:0] words_o
);
  logic            busy_q, busy_d;
  logic [CHW-1:0]  ch_q, ch_d;
  logic [BITW-1:0] bit_q, bit_d;
  logic [ADCW-1:0] res_q, res_d;
  logic            done_q;
  logic [ADCW-1:0] trial, res_nxt;
  logic            last_bit, last_ch;

  always_comb begin
    trial    = res_q | (ADCW'(1) << bit_q);
    res_nxt  = comp_i ? trial : res_q;
    last_bit = busy_q && (bit_q == '0);
    last_ch  = (ch_q == CHW'(NCH-1));
    busy_d   = busy_q;
    ch_d     = ch_q;
    bit_d    = bit_q;
    res_d    = res_q;
    if (!busy_q) begin
      if (go_i) begin
        busy_d = 1'b1;
        ch_d   = '0;
        bit_d  = BITW'(ADCW-1);
        res_d  = '0;
      end
    end else if (last_bit) begin
      res_d = '0;
      bit_d = BITW'(ADCW-1);
      if (last_ch) begin
        busy_d = 1'b0;
        ch_d   = '0;
      end else begin
        ch_d = ch_q + 1'b1;
      end
    end else begin
      res_d = res_nxt;
      bit_d = bit_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= '0;
      bit_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ch_q   <= ch_d;
      bit_q  <= bit_d;
      res_q  <= res_d;
      done_q <= last_bit && last_ch;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_word
    logic [ADCW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (last_bit && (ch_q == CHW'(g))) word_q <= res_nxt;
    end
    assign words_o[g*ADCW +: ADCW] = word_q;
  end

  assign busy_o  = busy_q;
  assign sel_o   = ch_q;
  assign trial_o = busy_q ? trial : '0;
  assign done_o  = done_q;
endmodule

// File: rtl/ccd_ser_out.sv
module ccd_ser_out
  import ccd_pkg::*;
#(
  parameter int unsigned ADCW = CCD_ADCW,
  parameter int unsigned NCH  = CCD_NCH,
  localparam int unsigned REMW = $clog2(ADCW+1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [NCH*ADCW-1:0] words_i,
  output logic [NCH-1:0]      ser_o,
  output logic                shift_o,
  output logic                word_o
);
  logic [REMW-1:0] rem_q;
  logic            active;

  assign active = (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (load_i) rem_q <= REMW'(ADCW);
    else if (active) rem_q <= rem_q - 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic [ADCW-1:0] sr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= '0;
      else if (load_i) sr_q <= words_i[g*ADCW +: ADCW];
      else if (active) sr_q <= {sr_q[ADCW-2:0], 1'b0};
    end
    assign ser_o[g] = active & sr_q[ADCW-1];
  end

  assign shift_o = active;
  assign word_o  = (rem_q == REMW'(ADCW));
endmodule

// File: rtl/ccd_cfg_regs.sv
module ccd_cfg_regs
  import ccd_pkg::*;
#(
  parameter int unsigned NCH  = CCD_NCH,
  parameter int unsigned CFGW = CCD_CFGW,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [CHW-1:0]      ch_i,
  input  logic                gain_sel_i,
  input  logic [CFGW-1:0]     data_i,
  output logic [NCH*CFGW-1:0] offs_o,
  output logic [NCH*CFGW-1:0] gain_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CFGW-1:0] offs_q, gain_q;
    logic            hit;
    assign hit = we_i && (ch_i == CHW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offs_q <= '0;
        gain_q <= '0;
      end else if (hit) begin
        if (gain_sel_i) gain_q <= data_i;
        else            offs_q <= data_i;
      end
    end
    assign offs_o[g*CFGW +: CFGW] = offs_q;
    assign gain_o[g*CFGW +: CFGW] = gain_q;
  end
endmodule

// File: rtl/ccd_pix_seq.sv
module ccd_pix_seq
  import ccd_pkg::*;
#(
  parameter int unsigned NCH  = CCD_NCH,
  parameter int unsigned POSW = CCD_POSW,
  parameter int unsigned ADCW = CCD_ADCW,
  parameter int unsigned CFGW = CCD_CFGW,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [POSW-1:0]     blk_pos_i,
  input  logic [POSW-1:0]     vid_pos_i,
  input  logic                comp_i,
  input  logic                cfg_we_i,
  input  logic [CHW-1:0]      cfg_ch_i,
  input  logic                cfg_gain_sel_i,
  input  logic [CFGW-1:0]     cfg_data_i,
  output logic                blk_smp_o,
  output logic                vid_smp_o,
  output logic                order_err_o,
  output logic                overrun_o,
  output logic                conv_busy_o,
  output logic [CHW-1:0]      mux_sel_o,
  output logic [ADCW-1:0]     sar_trial_o,
  output logic [NCH-1:0]      ser_o,
  output logic                shift_o,
  output logic                word_o,
  output logic [NCH*CFGW-1:0] offs_o,
  output logic [NCH*CFGW-1:0] gain_o
);
  logic                handoff, conv_done;
  logic [NCH*ADCW-1:0] words;

  ccd_samp_seq #(.POSW(POSW)) u_samp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .blk_pos_i(blk_pos_i), .vid_pos_i(vid_pos_i),
    .conv_idle_i(~conv_busy_o),
    .blk_smp_o(blk_smp_o), .vid_smp_o(vid_smp_o),
    .order_err_o(order_err_o), .overrun_o(overrun_o),
    .handoff_o(handoff)
  );

  ccd_sar_conv #(.ADCW(ADCW), .NCH(NCH)) u_sar (
    .clk(clk), .rst_n(rst_n), .go_i(handoff), .comp_i(comp_i),
    .busy_o(conv_busy_o), .sel_o(mux_sel_o), .trial_o(sar_trial_o),
    .done_o(conv_done), .words_o(words)
  );

  ccd_ser_out #(.ADCW(ADCW), .NCH(NCH)) u_ser (
    .clk(clk), .rst_n(rst_n), .load_i(conv_done), .words_i(words),
    .ser_o(ser_o), .shift_o(shift_o), .word_o(word_o)
  );

  ccd_cfg_regs #(.NCH(NCH), .CFGW(CFGW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .ch_i(cfg_ch_i),
    .gain_sel_i(cfg_gain_sel_i), .data_i(cfg_data_i),
    .offs_o(offs_o), .gain_o(gain_o)
  );
endmodule

// File: rtl/ccd_pix_seq_chk.sv
module ccd_pix_seq_chk #(
  parameter int unsigned NCH  = 3,
  parameter int unsigned ADCW = 10,
  parameter int unsigned CFGW = 8,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we_i,
  input logic                blk_smp_o,
  input logic                vid_smp_o,
  input logic                order_err_o,
  input logic                overrun_o,
  input logic                conv_busy_o,
  input logic [CHW-1:0]      mux_sel_o,
  input logic                shift_o,
  input logic                word_o,
  input logic [NCH*CFGW-1:0] offs_o,
  input logic [NCH*CFGW-1:0] gain_o
);
  logic       seen_blk_q;
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_blk_q <= 1'b0;
      run_q      <= '0;
    end else begin
      if (vid_smp_o)      seen_blk_q <= 1'b0;
      else if (blk_smp_o) seen_blk_q <= 1'b1;
      run_q <= shift_o ? run_q + 1'b1 : 8'd0;
    end
  end

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_smp_o && vid_smp_o));
  p_vid_after_blk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_smp_o |-> seen_blk_q);
  p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(overrun_o && order_err_o));
  p_red_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy_o) |-> (mux_sel_o == '0));
  p_chan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy_o && $past(conv_busy_o) && (mux_sel_o != $past(mux_sel_o)))
      |-> (mux_sel_o == $past(mux_sel_o) + 1'b1));
  p_mark_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_o |=> (shift_o && !word_o));
  p_mark_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_o |-> shift_o);
  p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_o) |-> (run_q == 8'(ADCW)));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> ($stable(gain_o) && $stable(offs_o)));
endmodule

bind ccd_pix_seq ccd_pix_seq_chk #(.NCH(NCH), .ADCW(ADCW), .CFGW(CFGW)) u_chk (.*);

// File: tb/ccd_pix_seq_tb.sv
module ccd_pix_seq_tb;
  logic        clk, rst_n;
  logic        start_i;
  logic [7:0]  blk_pos_i, vid_pos_i;
  logic        comp_i;
  logic        cfg_we_i;
  logic [1:0]  cfg_ch_i;
  logic        cfg_gain_sel_i;
  logic [7:0]  cfg_data_i;
  logic        blk_smp_o, vid_smp_o, order_err_o, overrun_o, conv_busy_o;
  logic [1:0]  mux_sel_o;
  logic [9:0]  sar_trial_o;
  logic [2:0]  ser_o;
  logic        shift_o, word_o;
  logic [23:0] offs_o, gain_o;

  int checks = 0, fails = 0;
  int conv_pix = 0, ser_pix = 0, accepted = 0;
  logic [9:0] val [64][3];
  logic [7:0] m_offs [3], m_gain [3];

  ccd_pix_seq u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // comparator model: channel value of the pixel currently converting
  assign comp_i = (val[conv_pix][mux_sel_o] >= sar_trial_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // conversion order tracker and serial receiver
  logic prev_busy = 1'b0;
  logic [9:0] sw [3];
  int bitcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_busy && !conv_busy_o) conv_pix++;
      prev_busy = conv_busy_o;
      if (shift_o) begin
        if (bitcnt == 0) chk(word_o == 1'b1, "R6 word marker on first bit", int'(word_o), 1);
        for (int c = 0; c < 3; c++) sw[c] = {sw[c][8:0], ser_o[c]};
        bitcnt++;
        if (bitcnt == 10) begin
          for (int c = 0; c < 3; c++)
            chk(sw[c] == val[ser_pix][c], "R5 R6 serial word", int'(sw[c]), int'(val[ser_pix][c]));
          ser_pix++;
          bitcnt = 0;
        end
      end else if (bitcnt != 0) begin
        chk(1'b0, "R6 shift run broken", bitcnt, 10);
        bitcnt = 0;
      end
    end
  end

  // one pixel; optionally an intruding start at count ovr_at (R4)
  task automatic run_pix(input int bp, input int vp, input int hi, input int ovr_at,
                         input bit chk_busy);
    int k, kb, kv;
    @(negedge clk);
    blk_pos_i = 8'(bp); vid_pos_i = 8'(vp); start_i = 1'b1;
    repeat (hi) @(negedge clk);
    start_i = 1'b0;
    k = 0; kb = -1; kv = -1;
    while (k < 300 && kv < 0) begin
      @(negedge clk);
      k++;
      if (ovr_at > 0 && k == ovr_at + 1) begin
        chk(overrun_o == 1'b1, "R4 overrun flag while counting", int'(overrun_o), 1);
        start_i = 1'b0;
      end
      if (ovr_at > 0 && k == ovr_at) begin
        start_i = 1'b1; blk_pos_i = 8'd0; vid_pos_i = 8'd1;
      end
      if (blk_smp_o && kb < 0) kb = k;
      if (vid_smp_o) begin
        kv = k;
        if (chk_busy) chk(conv_busy_o == 1'b1, "R7 sampling overlaps conversion", int'(conv_busy_o), 1);
      end
    end
    chk(kb == bp + 1, "R2 black strobe position", kb, bp + 1);
    chk(kv == vp + 1, "R2 video strobe position", kv, vp + 1);
    accepted++;
  endtask

  task automatic cfg_write(input int ch, input bit g, input int d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch); cfg_gain_sel_i = g; cfg_data_i = 8'(d);
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (ch < 3) begin
      if (g) m_gain[ch] = 8'(d); else m_offs[ch] = 8'(d);
    end
    chk(gain_o == {m_gain[2], m_gain[1], m_gain[0]}, "R8 gain outputs", int'(gain_o),
        int'({m_gain[2], m_gain[1], m_gain[0]}));
    chk(offs_o == {m_offs[2], m_offs[1], m_offs[0]}, "R8 offset outputs", int'(offs_o),
        int'({m_offs[2], m_offs[1], m_offs[0]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int seed, bp, vp, nstrobe;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int p = 0; p < 64; p++)
      for (int c = 0; c < 3; c++) val[p][c] = 10'($urandom % 1024);
    val[0][0] = 10'd0;   val[0][1] = 10'd1023; val[0][2] = 10'd512;
    val[1][0] = 10'd1;   val[1][1] = 10'd1022; val[1][2] = 10'h2AA;
    for (int c = 0; c < 3; c++) begin m_offs[c] = 8'd0; m_gain[c] = 8'd0; end
    rst_n = 1'b0; start_i = 1'b0; blk_pos_i = '0; vid_pos_i = '0;
    cfg_we_i = 1'b0; cfg_ch_i = '0; cfg_gain_sel_i = 1'b0; cfg_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({blk_smp_o, vid_smp_o, order_err_o, overrun_o, conv_busy_o, shift_o, word_o} == 7'd0,
        "R1 reset strobes and flags", 0, 0);
    chk(sar_trial_o == 10'd0 && ser_o == 3'd0, "R1 reset trial and serial", int'(sar_trial_o), 0);
    chk(gain_o == 24'd0 && offs_o == 24'd0, "R1 reset settings", int'(gain_o), 0);

    // R8 directed settings, channel 3 ignored
    cfg_write(0, 1'b0, 8'h11);
    cfg_write(1, 1'b1, 8'hA5);
    cfg_write(2, 1'b1, 8'hFF);
    cfg_write(3, 1'b1, 8'h77);
    cfg_write(3, 1'b0, 8'h33);

    // R2 corner positions: 0/1 and 254/255
    run_pix(0, 1, 1, 0, 1'b0);
    repeat (40) @(negedge clk);
    run_pix(254, 255, 3, 0, 1'b0);
    repeat (40) @(negedge clk);

    // R3 order errors: equal and reversed positions
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      blk_pos_i = 8'd10; vid_pos_i = (t == 0) ? 8'd10 : 8'd4; start_i = 1'b1;
      @(negedge clk);
      chk(order_err_o == 1'b1, "R3 order error flag", int'(order_err_o), 1);
      start_i = 1'b0;
      nstrobe = 0;
      repeat (40) begin
        @(negedge clk);
        if (blk_smp_o || vid_smp_o) nstrobe++;
      end
      chk(nstrobe == 0, "R3 dropped pixel gives no strobe", nstrobe, 0);
    end

    // R4 overrun during counting, timing unchanged
    run_pix(20, 40, 2, 5, 1'b0);
    repeat (40) @(negedge clk);

    // R7 back-to-back pixels, then R4 overrun while a pixel is held
    run_pix(0, 1, 1, 0, 1'b0);
    repeat (2) @(negedge clk);
    run_pix(0, 1, 1, 0, 1'b1);
    repeat (2) @(negedge clk);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk(overrun_o == 1'b1, "R4 overrun flag while samples held", int'(overrun_o), 1);
    start_i = 1'b0;
    repeat (80) @(negedge clk);

    // constrained random pixels
    for (int n = 0; n < 30; n++) begin
      bp = int'($urandom % 100);
      vp = bp + 1 + int'($urandom % 100);
      run_pix(bp, vp, 1 + int'($urandom % 4), 0, 1'b0);
      repeat (35 + int'($urandom % 10)) @(negedge clk);
    end

    // random settings
    for (int n = 0; n < 12; n++)
      cfg_write(int'($urandom % 4), 1'($urandom % 2), int'($urandom % 256));

    repeat (80) @(negedge clk);
    chk(conv_pix == accepted, "R5 conversions match accepted pixels", conv_pix, accepted);
    chk(ser_pix == accepted, "R6 R7 words sent match accepted pixels", ser_pix, accepted);
    finish_run();
  end
endmodule